// File: doc/BRIEF.md
# I2C Packet Header Parser

This block sits between a transmit word FIFO and a bit-level I2C engine. It reads a three-word header that describes one transfer: a routing word, a length word and a flag-and-address word. It then drives the engine one command at a time: a start condition, one or more address bytes, the payload bytes and an optional stop. For writes it splits each 32-bit payload word into bytes, lowest byte first. For reads it collects the returned bytes and packs them into words for a receive FIFO. It pulses a completion flag at the end of a packet and an error flag when a target does not acknowledge.

A packet can end with a stop, or it can keep the bus. If it keeps the bus, the next packet opens with a repeated start, or it carries on the same transfer with no start and no address. Software therefore chains several packets into one bus transaction purely by what it writes into the FIFO.

Top module: `i2c_pkt_parser`

## Requirements
- R1: No header word is popped and no command is issued until `txf_level` is at least 3. The three header words are then popped on consecutive cycles, and `txf_pop` is never high while `txf_level` is 0.
- R2: Bits LEN_W-1:0 of header word 1 hold the payload length minus one. The packet issues exactly that many data commands plus one, and `cmd_last` is high only on the final data command.
- R3: Command codes on `cmd_op` are 0 for start, 1 for stop, 2 for write byte and 3 for read byte. A packet whose bit 18 of word 2 is clear opens with start, then writes `{word2[7:1], rd}`, where rd is bit 19 of word 2.
- R4: When bit 18 is set, the address is word2[9:0]. The packet opens with start, writes `{5'b11110, a[9:8], 1'b0}`, then writes a[7:0]. For a read (bit 19) it follows this with start and writes `{5'b11110, a[9:8], 1'b1}`.
- R5: When bit 20 is set, the packet writes 0x01 after the opening start, ignores that byte's acknowledge, and issues a second start before the address.
- R6: Write payload bytes are taken lowest byte first, four per word. Unused upper bytes of a partial last word are dropped, and the next header starts at the next FIFO word.
- R7: Read payload bytes are packed lowest byte first. A word is pushed when four bytes are in it, or right after the final byte, with its unused upper bytes zero.
- R8: With bits 16 and 15 of word 2 both clear, the packet ends with stop. With bit 16 set it issues no stop, and the next packet opens with start and address. Bit 16 takes priority when both bits are set. With bit 15 alone it issues no stop, and the next packet goes straight to its payload with no start and no address.
- R9: `pkt_done` pulses for one cycle after the last byte, and after the stop when there is one, only when bit 17 of word 2 is set. It never pulses for a packet that ended in error.
- R10: A write byte answered with `rsp_nack` while bit 21 is clear makes `nack_err` pulse once, before the stop is issued. The next command is stop, and no further data commands follow. With bit 21 set, the negative acknowledge is ignored.
- R11: `cmd_hs` equals bit 22 of word 2 for every command of the packet.
- R12: While `cmd_valid` is high and `cmd_done` is low, `cmd_op`, `cmd_byte` and `cmd_last` hold their values until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txf_data | input | DATA_W | Word at the head of the transmit FIFO |
| txf_level | input | LVL_W | Number of words in the transmit FIFO |
| txf_pop | output | 1 | Removes the head word from the transmit FIFO |
| cmd_valid | output | 1 | A bus command is presented to the engine |
| cmd_op | output | 2 | Command code (start, stop, write, read) |
| cmd_byte | output | 8 | Byte to write |
| cmd_last | output | 1 | Final data byte of the packet |
| cmd_hs | output | 1 | High-speed request for the engine |
| cmd_done | input | 1 | Engine finished the current command |
| rsp_nack | input | 1 | Byte was not acknowledged (valid with cmd_done) |
| rsp_byte | input | 8 | Byte read from the bus (valid with cmd_done) |
| rxf_push | output | 1 | Writes a packed word to the receive FIFO |
| rxf_data | output | DATA_W | Packed receive word |
| pkt_done | output | 1 | Packet completion pulse |
| nack_err | output | 1 | Missing-acknowledge error pulse |

## Verification
The main function is tried with a table of headers that covers 7-bit writes and reads, 10-bit writes and reads, the start-byte prefix, high-speed requests, completion enabled and disabled, and lengths of 1 to 6 bytes. The different lengths show whether a full word, a partial word or a word boundary is handled. Reads of 1, 2 and 6 bytes show whether the partial-word push and the zero fill work. Chained pairs of packets tell the stop, repeated-start and continue endings apart, and one pair sets both ending bits to check which one wins. Negative acknowledges on the address and on a data byte, with bit 21 set and with it clear, show whether an error is raised or ignored, and whether it is raised before the stop.

// File: rtl/i2c_pkt_pkg.sv
package i2c_pkt_pkg;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } bus_op_e;

   // flag positions inside header word 2
   localparam int FB_HS    = 22;
   localparam int FB_CNAK  = 21;
   localparam int FB_SBYTE = 20;
   localparam int FB_RD    = 19;
   localparam int FB_A10   = 18;
   localparam int FB_IE    = 17;
   localparam int FB_RS    = 16;
   localparam int FB_CT    = 15;
   localparam int FB_LO    = FB_CT;
   localparam int FB_HI    = FB_HS;

   typedef struct packed {
      logic       hs;
      logic       cnak;
      logic       sbyte;
      logic       rd;
      logic       a10;
      logic       ie;
      logic       rs;
      logic       ct;
      logic [9:0] addr;
   } pkt_flags_t;

endpackage

// File: rtl/pkt_hdr_decode.sv
module pkt_hdr_decode
   import i2c_pkt_pkg::*;
(
   input  logic [FB_HI-FB_LO:0] flag_bits,
   input  logic [9:0]           addr_bits,
   output pkt_flags_t           flags
);
   always_comb begin
      flags.hs    = flag_bits[FB_HS - FB_LO];
      flags.cnak  = flag_bits[FB_CNAK - FB_LO];
      flags.sbyte = flag_bits[FB_SBYTE - FB_LO];
      flags.rd    = flag_bits[FB_RD - FB_LO];
      flags.a10   = flag_bits[FB_A10 - FB_LO];
      flags.ie    = flag_bits[FB_IE - FB_LO];
      flags.rs    = flag_bits[FB_RS - FB_LO];
      flags.ct    = flag_bits[FB_CT - FB_LO];
      flags.addr  = addr_bits;
   end
endmodule

// File: rtl/pkt_tx_unpack.sv
module pkt_tx_unpack #(
   parameter int DATA_W = 32,
   localparam int BPW    = DATA_W / 8,
   localparam int LANE_W = $clog2(BPW)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic [LANE_W-1:0] lane,
   output logic [7:0]        byte_out
);
   logic [DATA_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    word_q <= '0;
      else if (load) word_q <= din;
   end

   assign byte_out = word_q[lane*8 +: 8];
endmodule

// File: rtl/pkt_rx_pack.sv
module pkt_rx_pack #(
   parameter int DATA_W = 32,
   localparam int BPW    = DATA_W / 8,
   localparam int LANE_W = $clog2(BPW)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [7:0]        din,
   input  logic [LANE_W-1:0] lane,
   input  logic              last,
   output logic              push,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] acc_nxt;

   for (genvar g = 0; g < BPW; g++) begin : g_lane
      assign acc_nxt[g*8 +: 8] = (lane == LANE_W'(g)) ? din :
                                 (lane == '0)         ? 8'h00 :
                                                        acc_q[g*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         push  <= 1'b0;
         dout  <= '0;
      end else begin
         push <= take && (last || lane == LANE_W'(BPW-1));
         if (take) begin
            acc_q <= acc_nxt;
            dout  <= acc_nxt;
         end
      end
   end

   // R7
   mid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !last && lane != LANE_W'(BPW-1)) |=> !push);
endmodule

// File: rtl/i2c_pkt_parser.sv
module i2c_pkt_parser
   import i2c_pkt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16,
   parameter int LVL_W  = 6,
   localparam int BPW    = DATA_W / 8,
   localparam int LANE_W = $clog2(BPW)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] txf_data,
   input  logic [LVL_W-1:0]  txf_level,
   output logic              txf_pop,
   output logic              cmd_valid,
   output logic [1:0]        cmd_op,
   output logic [7:0]        cmd_byte,
   output logic              cmd_last,
   output logic              cmd_hs,
   input  logic              cmd_done,
   input  logic              rsp_nack,
   input  logic [7:0]        rsp_byte,
   output logic              rxf_push,
   output logic [DATA_W-1:0] rxf_data,
   output logic              pkt_done,
   output logic              nack_err
);
   if (DATA_W < 32 || DATA_W % 8 != 0) begin : g_bad_w
      $error("DATA_W must be a multiple of 8 and at least 32");
   end
   if ((BPW & (BPW - 1)) != 0) begin : g_bad_bpw
      $error("bytes per word must be a power of two");
   end
   if (LEN_W < 1 || LEN_W > DATA_W) begin : g_bad_len
      $error("LEN_W out of range");
   end
   if (LVL_W < 2) begin : g_bad_lvl
      $error("LVL_W must be able to hold 3");
   end

   typedef enum logic [3:0] {
      S_IDLE, S_HDR, S_START, S_SBYTE, S_SRST, S_ADR0, S_ADR1, S_ARST,
      S_ADR2, S_LOAD, S_WR, S_RD, S_END, S_FIN, S_ERR, S_ESTOP
   } st_e;

   st_e               st;
   logic [1:0]        hidx;
   logic [LEN_W-1:0]  cnt;
   logic [LANE_W-1:0] lane;
   logic              chained;
   pkt_flags_t        fl, dec;
   logic [7:0]        tx_byte;
   bus_op_e           op;
   logic              nack_fail;
   logic              last_byte;

   pkt_hdr_decode u_dec (
      .flag_bits (txf_data[FB_HI:FB_LO]),
      .addr_bits (txf_data[9:0]),
      .flags     (dec)
   );

   pkt_tx_unpack #(.DATA_W(DATA_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (st == S_LOAD && txf_level != '0),
      .din      (txf_data),
      .lane     (lane),
      .byte_out (tx_byte)
   );

   pkt_rx_pack #(.DATA_W(DATA_W)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (st == S_RD && cmd_done),
      .din   (rsp_byte),
      .lane  (lane),
      .last  (last_byte),
      .push  (rxf_push),
      .dout  (rxf_data)
   );

   assign last_byte = (cnt == '0);
   assign nack_fail = cmd_done && rsp_nack && !fl.cnak;
   assign txf_pop   = (st == S_HDR) || (st == S_LOAD && txf_level != '0);
   assign pkt_done  = (st == S_FIN) && fl.ie;
   assign nack_err  = (st == S_ERR);
   assign cmd_hs    = fl.hs;
   assign cmd_op    = op;

   always_comb begin
      cmd_valid = 1'b0;
      op        = OP_WRITE;
      cmd_byte  = 8'h00;
      cmd_last  = 1'b0;
      case (st)
         S_START, S_SRST, S_ARST: begin
            cmd_valid = 1'b1;
            op        = OP_START;
         end
         S_SBYTE: begin
            cmd_valid = 1'b1;
            cmd_byte  = 8'h01;
         end
         S_ADR0: begin
            cmd_valid = 1'b1;
            cmd_byte  = fl.a10 ? {5'b11110, fl.addr[9:8], 1'b0}
                               : {fl.addr[7:1], fl.rd};
         end
         S_ADR1: begin
            cmd_valid = 1'b1;
            cmd_byte  = fl.addr[7:0];
         end
         S_ADR2: begin
            cmd_valid = 1'b1;
            cmd_byte  = {5'b11110, fl.addr[9:8], 1'b1};
         end
         S_WR: begin
            cmd_valid = 1'b1;
            cmd_byte  = tx_byte;
            cmd_last  = last_byte;
         end
         S_RD: begin
            cmd_valid = 1'b1;
            op        = OP_READ;
            cmd_last  = last_byte;
         end
         S_END: begin
            cmd_valid = !(fl.rs || fl.ct);
            op        = OP_STOP;
         end
         S_ESTOP: begin
            cmd_valid = 1'b1;
            op        = OP_STOP;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         hidx    <= '0;
         cnt     <= '0;
         lane    <= '0;
         fl      <= '0;
         chained <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (txf_level >= LVL_W'(3)) begin
               st   <= S_HDR;
               hidx <= '0;
            end
            S_HDR: begin
               hidx <= hidx + 2'd1;
               if (hidx == 2'd1) cnt <= txf_data[LEN_W-1:0];
               if (hidx == 2'd2) begin
                  fl   <= dec;
                  lane <= '0;
                  if (chained) st <= dec.rd ? S_RD : S_LOAD;
                  else         st <= S_START;
               end
            end
            S_START: if (cmd_done) st <= fl.sbyte ? S_SBYTE : S_ADR0;
            S_SBYTE: if (cmd_done) st <= S_SRST;
            S_SRST:  if (cmd_done) st <= S_ADR0;
            S_ADR0: if (cmd_done) begin
               if (nack_fail)   st <= S_ERR;
               else if (fl.a10) st <= S_ADR1;
               else             st <= fl.rd ? S_RD : S_LOAD;
            end
            S_ADR1: if (cmd_done) begin
               if (nack_fail) st <= S_ERR;
               else           st <= fl.rd ? S_ARST : S_LOAD;
            end
            S_ARST: if (cmd_done) st <= S_ADR2;
            S_ADR2: if (cmd_done) st <= nack_fail ? S_ERR : S_RD;
            S_LOAD: if (txf_level != '0) begin
               lane <= '0;
               st   <= S_WR;
            end
            S_WR: if (cmd_done) begin
               if (nack_fail) st <= S_ERR;
               else if (last_byte) st <= S_END;
               else begin
                  cnt <= cnt - LEN_W'(1);
                  if (lane == LANE_W'(BPW-1)) st <= S_LOAD;
                  else lane <= lane + LANE_W'(1);
               end
            end
            S_RD: if (cmd_done) begin
               if (last_byte) st <= S_END;
               else begin
                  cnt  <= cnt - LEN_W'(1);
                  lane <= lane + LANE_W'(1);
               end
            end
            S_END: begin
               if (fl.rs) begin
                  chained <= 1'b0;
                  st      <= S_FIN;
               end else if (fl.ct) begin
                  chained <= 1'b1;
                  st      <= S_FIN;
               end else if (cmd_done) begin
                  chained <= 1'b0;
                  st      <= S_FIN;
               end
            end
            S_FIN: st <= S_IDLE;
            S_ERR: begin
               chained <= 1'b0;
               st      <= S_ESTOP;
            end
            S_ESTOP: if (cmd_done) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   // R1
   pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txf_pop |-> (txf_level != '0));

   // R1
   hdr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && txf_level < LVL_W'(3)) |=> !txf_pop);

   // R10
   nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nack_err |=> (cmd_valid && cmd_op == OP_STOP));

   // R9
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_done && (nack_err || cmd_valid)));

   // R12
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_done) |=>
         (cmd_valid && $stable(cmd_op) && $stable(cmd_byte) && $stable(cmd_last)));
endmodule

// File: tb/sim_i2c_pkt_parser.sv
module sim_i2c_pkt_parser;
   localparam int DW = 32;
   localparam int LW = 16;
   localparam int VW = 7;

   localparam logic [31:0] VW2 [8] = '{
      32'h0002_00A0, 32'h004A_0074, 32'h0000_0022, 32'h000A_00FE,
      32'h0006_02C5, 32'h000E_01F0, 32'h0012_0090, 32'h0022_0040 };
   localparam int VLEN  [8] = '{5, 6, 4, 1, 3, 2, 1, 2};
   localparam int VNACK [8] = '{-1, -1, -1, -1, -1, -1, -1, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [DW-1:0] txf_data;
   logic [VW-1:0] txf_level;
   logic txf_pop, cmd_valid, cmd_last, cmd_hs, cmd_done, rsp_nack;
   logic [1:0] cmd_op;
   logic [7:0] cmd_byte, rsp_byte;
   logic rxf_push, pkt_done, nack_err;
   logic [DW-1:0] rxf_data;

   i2c_pkt_parser #(.DATA_W(DW), .LEN_W(LW), .LVL_W(VW)) u0 (
      .clk(clk), .rst_n(rst_n), .txf_data(txf_data), .txf_level(txf_level),
      .txf_pop(txf_pop), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_byte(cmd_byte), .cmd_last(cmd_last), .cmd_hs(cmd_hs),
      .cmd_done(cmd_done), .rsp_nack(rsp_nack), .rsp_byte(rsp_byte),
      .rxf_push(rxf_push), .rxf_data(rxf_data), .pkt_done(pkt_done),
      .nack_err(nack_err));

   // transmit FIFO model
   logic [31:0] fmem [128];
   int wp = 0;
   int rp = 0;
   always_comb begin
      txf_level = VW'(wp - rp);
      txf_data  = fmem[rp & 127];
   end
   always @(posedge clk) begin
      if (!rst_n) rp <= 0;
      else if (txf_pop) rp <= rp + 1;
   end

   // engine model and observers
   logic clr = 1'b0;
   int nack_idx = -1;
   int busy, cur_idx, log_n, rd_cnt, rx_n, done_n, err_n, err_at;
   int lop [32];
   int lbyte [32];
   int llast [32];
   int lhs [32];
   logic [31:0] rx_w [16];

   always @(posedge clk) begin
      if (!rst_n || clr) begin
         busy <= 0; cmd_done <= 1'b0; rsp_nack <= 1'b0; rsp_byte <= 8'h00;
         log_n <= 0; rd_cnt <= 0; rx_n <= 0; done_n <= 0; err_n <= 0;
         err_at <= -1; cur_idx <= 0;
      end else begin
         cmd_done <= 1'b0;
         rsp_nack <= 1'b0;
         if (busy == 1) begin
            cmd_done <= 1'b1;
            rsp_nack <= (cur_idx == nack_idx);
            busy <= 0;
         end else if (busy > 1) begin
            busy <= busy - 1;
         end else if (cmd_valid && !cmd_done) begin
            if (log_n < 32) begin
               lop[log_n]   <= int'(cmd_op);
               lbyte[log_n] <= int'(cmd_byte);
               llast[log_n] <= int'(cmd_last);
               lhs[log_n]   <= int'(cmd_hs);
            end
            cur_idx <= log_n;
            log_n <= log_n + 1;
            busy <= 2;
            if (cmd_op == 2'd3) begin
               rsp_byte <= 8'hA0 + 8'(rd_cnt);
               rd_cnt <= rd_cnt + 1;
            end
         end
         if (rxf_push) begin
            if (rx_n < 16) rx_w[rx_n] <= rxf_data;
            rx_n <= rx_n + 1;
         end
         if (pkt_done) done_n <= done_n + 1;
         if (nack_err) begin
            err_n <= err_n + 1;
            err_at <= log_n;
         end
      end
   end

   // bench bookkeeping
   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   int eop [32];
   int ebyte [32];
   int elast [32];
   int en, ern, erd;
   logic [31:0] erx [16];

   task automatic chk(input bit ok, input string msg, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      wp = 0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic clear_obs();
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      en = 0; ern = 0; erd = 0;
   endtask

   task automatic push_word(input logic [31:0] w);
      fmem[wp & 127] = w;
      wp = wp + 1;
   endtask

   task automatic eadd(input int op, input int b, input int last);
      eop[en] = op; ebyte[en] = b; elast[en] = last;
      en++;
   endtask

   task automatic push_pkt(input logic [31:0] w2, input int len, input int base);
      push_word(32'h0001_0010);
      push_word(32'(len - 1));
      push_word(w2);
      if (!w2[19]) begin
         for (int w = 0; w < (len + 3) / 4; w++)
            push_word({8'(base + 4*w + 3), 8'(base + 4*w + 2),
                       8'(base + 4*w + 1), 8'(base + 4*w)});
      end
   endtask

   // expected commands from R3..R8
   task automatic exp_pkt(input logic [31:0] w2, input int len, input int base,
                          input bit opener);
      logic [31:0] word;
      if (opener) begin
         eadd(0, 0, 0);
         if (w2[20]) begin eadd(2, 8'h01, 0); eadd(0, 0, 0); end
         if (w2[18]) begin
            eadd(2, {5'b11110, w2[9:8], 1'b0}, 0);
            eadd(2, w2[7:0], 0);
            if (w2[19]) begin
               eadd(0, 0, 0);
               eadd(2, {5'b11110, w2[9:8], 1'b1}, 0);
            end
         end else begin
            eadd(2, {w2[7:1], w2[19]}, 0);
         end
      end
      word = '0;
      for (int i = 0; i < len; i++) begin
         if (w2[19]) begin
            eadd(3, 0, int'(i == len - 1));
            word[(i%4)*8 +: 8] = 8'hA0 + 8'(erd);
            erd++;
            if (i % 4 == 3 || i == len - 1) begin
               erx[ern] = word;
               ern++;
               word = '0;
            end
         end else begin
            eadd(2, (base + i) & 255, int'(i == len - 1));
         end
      end
      if (!(w2[16] || w2[15])) eadd(1, 0, 0);
   endtask

   task automatic cmp_seq(input string tag);
      int bad;
      int act;
      int expv;
      bad = -1;
      for (int i = 0; i < en && i < log_n; i++) begin
         if (bad < 0 && (lop[i] != eop[i] || llast[i] != elast[i] ||
                         (eop[i] != 3 && lbyte[i] != ebyte[i]))) bad = i;
      end
      if (bad >= 0) begin
         act  = (lop[bad] << 16) | (llast[bad] << 8) | lbyte[bad];
         expv = (eop[bad] << 16) | (elast[bad] << 8) | ebyte[bad];
      end else begin
         act = log_n; expv = en;
      end
      chk(bad < 0 && log_n == en, {tag, " command sequence"}, act, expv);
   endtask

   task automatic cmp_rx(input string tag);
      int bad;
      bad = -1;
      for (int i = 0; i < ern && i < rx_n; i++)
         if (bad < 0 && rx_w[i] != erx[i]) bad = i;
      if (bad >= 0)
         chk(1'b0, {tag, " rx word"}, int'(rx_w[bad]), int'(erx[bad]));
      else
         chk(rx_n == ern, {tag, " rx word count"}, rx_n, ern);
   endtask

   task automatic settle();
      repeat (300) @(negedge clk);
   endtask

   initial begin
      en = 0; ern = 0; erd = 0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(!cmd_valid && !txf_pop && !pkt_done && !nack_err && !rxf_push,
          "reset outputs idle", {cmd_valid, txf_pop, pkt_done, nack_err, rxf_push}, 0);

      // table of single packets: R2 R3 R4 R5 R6 R7 R9 R10 R11
      for (int v = 0; v < 8; v++) begin
         bit hs_ok;
         clear_obs();
         nack_idx = VNACK[v];
         push_pkt(VW2[v], VLEN[v], 16 + 8*v);
         exp_pkt(VW2[v], VLEN[v], 16 + 8*v, 1'b1);
         settle();
         cmp_seq($sformatf("R2 R3 R4 R5 R6 vec%0d", v));
         cmp_rx($sformatf("R7 vec%0d", v));
         chk(done_n == int'(VW2[v][17]), $sformatf("R9 vec%0d done pulses", v),
             done_n, int'(VW2[v][17]));
         chk(err_n == 0, $sformatf("R10 vec%0d no error (ack or bit21 set)", v), err_n, 0);
         hs_ok = 1'b1;
         for (int i = 0; i < log_n && i < 32; i++)
            if (lhs[i] != int'(VW2[v][22])) hs_ok = 1'b0;
         chk(hs_ok, $sformatf("R11 vec%0d cmd_hs", v), int'(hs_ok), 1);
         chk(txf_level == 0, $sformatf("R6 vec%0d fifo consumed", v), int'(txf_level), 0);
      end
      nack_idx = -1;

      // R1: header waits for three words
      clear_obs();
      push_word(32'h0001_0010);
      push_word(32'd0);
      repeat (40) @(negedge clk);
      chk(log_n == 0, "R1 no command with two header words", log_n, 0);
      chk(txf_level == 2, "R1 no pop with two header words", int'(txf_level), 2);
      push_word(32'h0002_00A0);
      push_word(32'h0000_0055);
      exp_pkt(32'h0002_00A0, 1, 8'h55, 1'b1);
      settle();
      cmp_seq("R1 after third word");

      // R8: repeated start ending
      clear_obs();
      push_pkt(32'h0003_00A0, 2, 8'h30);
      push_pkt(32'h000A_00A0, 1, 0);
      exp_pkt(32'h0003_00A0, 2, 8'h30, 1'b1);
      exp_pkt(32'h000A_00A0, 1, 0, 1'b1);
      settle();
      cmp_seq("R8 repeated start");
      cmp_rx("R8 R7 repeated start read");
      chk(done_n == 2, "R9 R8 two done pulses", done_n, 2);

      // R8: both bits set, repeated start wins
      clear_obs();
      push_pkt(32'h0003_80A0, 2, 8'h30);
      push_pkt(32'h000A_00A0, 1, 0);
      exp_pkt(32'h0003_00A0, 2, 8'h30, 1'b1);
      exp_pkt(32'h000A_00A0, 1, 0, 1'b1);
      settle();
      cmp_seq("R8 priority of repeated start");

      // R8: continue ending
      clear_obs();
      push_pkt(32'h0002_80A0, 2, 8'h30);
      push_pkt(32'h0002_00A0, 2, 8'h40);
      exp_pkt(32'h0002_80A0, 2, 8'h30, 1'b1);
      exp_pkt(32'h0002_00A0, 2, 8'h40, 1'b0);
      settle();
      cmp_seq("R8 continue without start");
      chk(done_n == 2, "R9 R8 continue done pulses", done_n, 2);

      // R10: NACK on a data byte
      clear_obs();
      nack_idx = 2;
      push_pkt(32'h0002_00A0, 4, 8'h10);
      eadd(0, 0, 0); eadd(2, 8'hA0, 0); eadd(2, 8'h10, 0); eadd(1, 0, 0);
      settle();
      cmp_seq("R10 nack on data");
      chk(err_n == 1, "R10 error pulse count", err_n, 1);
      chk(err_at == 3, "R10 error before stop issued", err_at, 3);
      chk(done_n == 0, "R9 R10 no done after error", done_n, 0);

      // R10: NACK on the address of a two-word write
      do_reset();
      clear_obs();
      nack_idx = 1;
      push_pkt(32'h0002_00A0, 5, 8'h10);
      eadd(0, 0, 0); eadd(2, 8'hA0, 0); eadd(1, 0, 0);
      settle();
      cmp_seq("R10 nack on address");
      chk(err_n == 1, "R10 address error pulse", err_n, 1);
      chk(done_n == 0, "R9 no done after address error", done_n, 0);
      nack_idx = -1;

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule